// File: doc/BRIEF.md
# DRAM Data Output Path Control

This block models how an asynchronous DRAM gates its data pins. It watches the active-low row strobe, column strobe, write enable and output enable, together with the read data the array presents for the addressed cell. From these it decides, cycle by cycle, whether the pins carry fresh array data, carry data held in an output latch, or float. The array and refresh logic stay outside; read data is an input.

All control inputs and the read data pass through a parameterised chain of sampling flops on a fast system clock. Edges are found by comparing the newest synchronised sample with the one before it. The block then tracks four things: an open row, a refresh started by column-before-row ordering, an early write, and data held after the row strobe rises. The outputs are a data bus and a drive enable for an external tristate buffer.

Top module: `dram_dout_ctrl`

## Requirements
- R1: During and right after reset, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: Read cycle. The row strobe falls while the column strobe is high, then the column strobe goes low with write enable high and output enable low. `dq_oe` becomes 1 and `dq_out` follows `rd_data`. An input level present at rising edge n appears on the outputs after edge n+SYNC_STAGES.
- R3: While the synchronised column strobe is high, `dq_oe` is 0 and the output latch does not change.
- R4: Page mode. Repeated column strobe pulses inside one row-low period each drive the read data present during that pulse.
- R5: Output enable high forces `dq_oe` to 0 but does not alter the latch. Returning it low shows the same latched value.
- R6: Write enable low while the column strobe is low forces `dq_oe` to 0. If write enable is low at the column strobe's falling edge (early write), the pins stay undriven for the rest of that pulse, even if write enable rises.
- R7: If the read path is open when the row strobe rises and the column strobe stays low, the latched data keeps driving. Later changes on `rd_data` are ignored until the column strobe rises.
- R8: A column strobe pulse while the row strobe is high and no data is held leaves `dq_oe` at 0 and `dq_out` unchanged.
- R9: Row-only refresh (row strobe low, column strobe high throughout) leaves `dq_oe` at 0 and `dq_out` unchanged.
- R10: Column strobe already low when the row strobe falls is a refresh. No read path opens, `dq_out` is unchanged, and the pins keep the state they had before: driving held data, or floating.
- R11: Late write. Before write enable falls, the pins are driven under output-enable control. Once write enable is low, they float and the latch stops updating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DATA_W | Array data for the addressed cell |
| dq_out | output | DATA_W | Output latch contents presented to the pins |
| dq_oe | output | 1 | Pin drive enable (0 = high impedance) |

## Verification
The hardest state to reach is a refresh started inside a held-data window. A read must open the path, the row strobe must rise with the column strobe still low, and then the row strobe must fall again. That last fall must be seen as a refresh, not a new row, while the pins keep driving the old value. The stimulus builds this exact order: a read, a row strobe rise, a change on `rd_data`, then a row strobe fall. A reference model that advances on every clock is compared against the pins throughout.

// File: rtl/dram_dout_pkg.sv
package dram_dout_pkg;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic oe_n;
   } dout_ctl_t;

   localparam dout_ctl_t CTL_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/dram_dout_sync.sv
module dram_dout_sync
   import dram_dout_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dout_ctl_t         ctl_in,
   input  logic [DATA_W-1:0] data_in,
   output dout_ctl_t         ctl_cur,
   output logic [DATA_W-1:0] data_cur,
   output logic              prev_ras_n,
   output logic              prev_cas_n
);

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctl_cur  <= CTL_IDLE;
               data_cur <= '0;
            end else begin
               ctl_cur  <= ctl_in;
               data_cur <= data_in;
            end
         end
      end else begin : g_chain
         dout_ctl_t         ctl_q  [STAGES];
         logic [DATA_W-1:0] data_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) begin
                  ctl_q[i]  <= CTL_IDLE;
                  data_q[i] <= '0;
               end
            end else begin
               ctl_q[0]  <= ctl_in;
               data_q[0] <= data_in;
               for (int i = 1; i < STAGES; i++) begin
                  ctl_q[i]  <= ctl_q[i-1];
                  data_q[i] <= data_q[i-1];
               end
            end
         end
         assign ctl_cur  = ctl_q[STAGES-1];
         assign data_cur = data_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ras_n <= 1'b1;
         prev_cas_n <= 1'b1;
      end else begin
         prev_ras_n <= ctl_cur.ras_n;
         prev_cas_n <= ctl_cur.cas_n;
      end
   end

endmodule

// File: rtl/dram_dout_cycle.sv
module dram_dout_cycle (
   input  logic clk,
   input  logic rst_n,
   input  logic cur_ras_n,
   input  logic cur_cas_n,
   input  logic cur_we_n,
   input  logic prev_ras_n,
   input  logic prev_cas_n,
   output logic path_nxt,
   output logic hold_nxt,
   output logic cbr_q
);

   logic row_q, early_q, hold_q, path_q;
   logic row_nxt, cbr_nxt, early_nxt;
   logic ras_fall, ras_rise, cas_fall;

   assign ras_fall = prev_ras_n & ~cur_ras_n;
   assign ras_rise = ~prev_ras_n & cur_ras_n;
   assign cas_fall = prev_cas_n & ~cur_cas_n;

   always_comb begin
      row_nxt = row_q;
      cbr_nxt = cbr_q;
      if (cur_ras_n) begin
         row_nxt = 1'b0;
         cbr_nxt = 1'b0;
      end else if (ras_fall) begin
         row_nxt = cur_cas_n;
         cbr_nxt = ~cur_cas_n;
      end

      early_nxt = early_q;
      if (cur_cas_n || !row_nxt)
         early_nxt = 1'b0;
      else if (cas_fall)
         early_nxt = ~cur_we_n;

      path_nxt = row_nxt & ~cur_cas_n & ~early_nxt & cur_we_n;

      hold_nxt = hold_q;
      if (cur_cas_n)
         hold_nxt = 1'b0;
      else if (ras_rise && path_q)
         hold_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= 1'b0;
         cbr_q   <= 1'b0;
         early_q <= 1'b0;
         hold_q  <= 1'b0;
         path_q  <= 1'b0;
      end else begin
         row_q   <= row_nxt;
         cbr_q   <= cbr_nxt;
         early_q <= early_nxt;
         hold_q  <= hold_nxt;
         path_q  <= path_nxt;
      end
   end

endmodule

// File: rtl/dram_dout_latch.sv
module dram_dout_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              path_nxt,
   input  logic              hold_nxt,
   input  logic              cur_we_n,
   input  logic              cur_oe_n,
   input  logic [DATA_W-1:0] data_cur,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   logic drive_nxt;

   assign drive_nxt = (path_nxt | hold_nxt) & ~cur_oe_n & cur_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out <= '0;
         dq_oe  <= 1'b0;
      end else begin
         if (path_nxt)
            dq_out <= data_cur;
         dq_oe <= drive_nxt;
      end
   end

endmodule

// File: rtl/dram_dout_ctrl.sv
module dram_dout_ctrl
   import dram_dout_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dram_dout_ctrl: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("dram_dout_ctrl: SYNC_STAGES must be at least 1");
      end
   endgenerate

   dout_ctl_t         ctl_in, ctl_cur;
   logic [DATA_W-1:0] data_cur;
   logic              prev_ras_n, prev_cas_n;
   logic              path_nxt, hold_nxt, cbr_q;

   assign ctl_in = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

   dram_dout_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_in     (ctl_in),
      .data_in    (rd_data),
      .ctl_cur    (ctl_cur),
      .data_cur   (data_cur),
      .prev_ras_n (prev_ras_n),
      .prev_cas_n (prev_cas_n)
   );

   dram_dout_cycle u_cycle (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_ras_n  (ctl_cur.ras_n),
      .cur_cas_n  (ctl_cur.cas_n),
      .cur_we_n   (ctl_cur.we_n),
      .prev_ras_n (prev_ras_n),
      .prev_cas_n (prev_cas_n),
      .path_nxt   (path_nxt),
      .hold_nxt   (hold_nxt),
      .cbr_q      (cbr_q)
   );

   dram_dout_latch #(.DATA_W(DATA_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .path_nxt (path_nxt),
      .hold_nxt (hold_nxt),
      .cur_we_n (ctl_cur.we_n),
      .cur_oe_n (ctl_cur.oe_n),
      .data_cur (data_cur),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

endmodule

// File: rtl/dram_dout_ctrl_chk.sv
module dram_dout_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_cas_n,
   input logic              s_we_n,
   input logic              s_oe_n,
   input logic              cbr_q,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   // R3
   cas_high_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_cas_n |=> !dq_oe);

   // R3
   cas_high_latch_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_cas_n |=> $stable(dq_out));

   // R5
   oe_high_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_oe_n |=> !dq_oe);

   // R6
   we_low_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_we_n && !s_cas_n) |=> !dq_oe);

   // R10
   refresh_latch_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_q |=> $stable(dq_out));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!dq_oe && dq_out == '0));

endmodule

bind dram_dout_ctrl dram_dout_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_cas_n (ctl_cur.cas_n),
   .s_we_n  (ctl_cur.we_n),
   .s_oe_n  (ctl_cur.oe_n),
   .cbr_q   (cbr_q),
   .dq_out  (dq_out),
   .dq_oe   (dq_oe)
);

// File: tb/dram_dout_ctrl_bench.sv
module dram_dout_ctrl_bench;

   localparam int W = 8;
   localparam int S = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [W-1:0] rd_data = '0;
   logic [W-1:0] dq_out;
   logic         dq_oe;

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   dram_dout_ctrl #(.DATA_W(W), .SYNC_STAGES(S)) u_dram_dout_ctrl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   // reference model: history of sampled inputs plus behavioural cycle state
   logic [W+3:0] hist[$];
   bit           m_row, m_cbr, m_early, m_hold, m_prev_path;
   logic [W-1:0] m_out;
   bit           m_oe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_row = 0; m_cbr = 0; m_early = 0; m_hold = 0; m_prev_path = 0;
         m_out = '0; m_oe = 0;
         hist.delete();
         repeat (S + 2) hist.push_back({4'hF, {W{1'b0}}});
      end else begin
         logic [W+3:0] s, p;
         bit path;
         hist.push_back({ras_n, cas_n, we_n, oe_n, rd_data});
         s = hist[hist.size() - 1 - S];
         p = hist[hist.size() - 2 - S];
         if (s[W+3]) begin
            m_row = 0; m_cbr = 0;
         end else if (p[W+3]) begin
            m_row = s[W+2]; m_cbr = !s[W+2];
         end
         if (s[W+2] || !m_row) m_early = 0;
         else if (p[W+2]) m_early = !s[W+1];
         path = m_row && !s[W+2] && !m_early && s[W+1];
         if (s[W+2]) m_hold = 0;
         else if (s[W+3] && !p[W+3] && m_prev_path) m_hold = 1;
         m_prev_path = path;
         if (path) m_out = s[W-1:0];
         m_oe = (path || m_hold) && !s[W] && s[W+1];
         if (hist.size() > S + 3) void'(hist.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (dq_oe !== m_oe || dq_out !== m_out) begin
            fails++;
            $display("FAIL %s model compare: actual oe=%0b out=%h expected oe=%0b out=%h",
                     cur_req, dq_oe, dq_out, m_oe, m_out);
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_pins(input string req, input bit oe_exp, input logic [W-1:0] d_exp);
      checks++;
      if (dq_oe !== oe_exp || dq_out !== d_exp) begin
         fails++;
         $display("FAIL %s: actual oe=%0b out=%h expected oe=%0b out=%h",
                  req, dq_oe, dq_out, oe_exp, d_exp);
      end
   endtask

   localparam int SETTLE = S + 2;

   initial begin
      wait_cyc(3);
      // R1 reset state
      expect_pins("R1", 0, 8'h00);
      rst_n = 1'b1;
      wait_cyc(1);
      expect_pins("R1", 0, 8'h00);

      // R2 read cycle
      cur_req = "R2";
      ras_n = 0; wait_cyc(3);
      oe_n = 0; rd_data = 8'hA5; cas_n = 0;
      wait_cyc(S);
      expect_pins("R2", 0, 8'h00);
      wait_cyc(1);
      expect_pins("R2", 1, 8'hA5);
      rd_data = 8'h3C; wait_cyc(SETTLE);
      expect_pins("R2", 1, 8'h3C);

      // R5 output enable
      cur_req = "R5";
      oe_n = 1; wait_cyc(SETTLE);
      expect_pins("R5", 0, 8'h3C);
      oe_n = 0; wait_cyc(SETTLE);
      expect_pins("R5", 1, 8'h3C);

      // R3 and R4 page mode
      cur_req = "R3";
      cas_n = 1; rd_data = 8'hEE; wait_cyc(SETTLE);
      expect_pins("R3", 0, 8'h3C);
      cur_req = "R4";
      rd_data = 8'h5A; cas_n = 0; wait_cyc(SETTLE);
      expect_pins("R4", 1, 8'h5A);
      cas_n = 1; wait_cyc(2); rd_data = 8'h77; cas_n = 0; wait_cyc(SETTLE);
      expect_pins("R4", 1, 8'h77);

      // R11 late write, then read again
      cur_req = "R11";
      we_n = 0; rd_data = 8'h12; wait_cyc(SETTLE);
      expect_pins("R11", 0, 8'h77);
      rd_data = 8'h77; we_n = 1; wait_cyc(SETTLE);
      expect_pins("R11", 1, 8'h77);
      cas_n = 1; wait_cyc(2); ras_n = 1; wait_cyc(4);

      // R6 early write
      cur_req = "R6";
      ras_n = 0; wait_cyc(2); we_n = 0; wait_cyc(2); rd_data = 8'h81; cas_n = 0;
      wait_cyc(SETTLE);
      expect_pins("R6", 0, 8'h77);
      we_n = 1; wait_cyc(SETTLE);
      expect_pins("R6", 0, 8'h77);
      cas_n = 1; wait_cyc(2); ras_n = 1; wait_cyc(4);

      // R7 hold after row strobe rise
      cur_req = "R7";
      ras_n = 0; wait_cyc(2); rd_data = 8'h99; cas_n = 0; wait_cyc(SETTLE);
      expect_pins("R7", 1, 8'h99);
      ras_n = 1; wait_cyc(SETTLE);
      expect_pins("R7", 1, 8'h99);
      rd_data = 8'h11; wait_cyc(SETTLE);
      expect_pins("R7", 1, 8'h99);
      cur_req = "R5";
      oe_n = 1; wait_cyc(SETTLE);
      expect_pins("R5", 0, 8'h99);
      oe_n = 0; wait_cyc(SETTLE);
      expect_pins("R5", 1, 8'h99);

      // R10 refresh inside held window
      cur_req = "R10";
      ras_n = 0; wait_cyc(SETTLE);
      expect_pins("R10", 1, 8'h99);
      ras_n = 1; wait_cyc(2); cas_n = 1; wait_cyc(SETTLE);
      expect_pins("R3", 0, 8'h99);

      // R8 column-only pulse
      cur_req = "R8";
      rd_data = 8'h22; cas_n = 0; wait_cyc(SETTLE);
      expect_pins("R8", 0, 8'h99);
      cas_n = 1; wait_cyc(3);

      // R9 row-only refresh
      cur_req = "R9";
      rd_data = 8'h44; ras_n = 0; wait_cyc(SETTLE + 2);
      expect_pins("R9", 0, 8'h99);
      ras_n = 1; wait_cyc(3);

      // R10 refresh from floating pins
      cur_req = "R10";
      cas_n = 0; wait_cyc(2); ras_n = 0; wait_cyc(SETTLE + 2);
      expect_pins("R10", 0, 8'h99);
      ras_n = 1; wait_cyc(2); cas_n = 1; wait_cyc(SETTLE);
      expect_pins("R10", 0, 8'h99);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule